// File: doc/BRIEF.md
# Indirect Pattern RAM Access Port

This block gives a host indirect read and write access to a pattern store of 128 words, each 40 bits wide. The host sees only two 32-bit registers. The low register, at offset 0x0, carries a 7-bit word index and three of the five data bytes. The high register, at offset 0x4, carries the other two bytes. Writing the low register selects a word and stages three bytes, but it does not change the store. Writing the high register commits a whole 40-bit word, which is built from the two bytes in that write and the three staged bytes, into the selected word.

Each time the index is written, and after each commit, the selected word is fetched into a read buffer one cycle later. Host reads of either register then show that word, and the two registers may be read in either order. A mode input hands the store to an external matching engine. While the mode is set, the host is locked out: its writes are dropped and its reads return all ones. The engine reads through its own port, which works only while the mode is set.

Top module: `patram_window`

## Requirements
- R1: Reset sets the word index, the staged bytes, the read buffer, `host_rdata` and `eng_rdata` to zero.
- R2: A host write to offset 0x0 with `match_mode` low loads the word index from bits 6:0. It stages data byte 0 from bits 15:8, byte 1 from bits 23:16 and byte 2 from bits 31:24. It leaves the store unchanged.
- R3: A host write to offset 0x4 with `match_mode` low issues a single-cycle store write. The word at the current index receives byte 3 from bits 7:0, byte 4 from bits 15:8, and bytes 0 to 2 from the staged bytes. Byte k occupies word bits 8k+7:8k.
- R4: One cycle after a low-register write or a commit, the read buffer holds the selected word. From then on, reads of offset 0x0 return {byte2, byte1, byte0, 1'b0, index}, and reads of offset 0x4 return {16'h0000, byte4, byte3}, in either order.
- R5: `host_rdata` changes only on the clock edge where `host_rd` is sampled high, so it is valid in the next cycle and holds otherwise. A read of any offset other than 0x0 or 0x4 returns zero.
- R6: While `match_mode` is high, host writes to either register are ignored: the index, the staged bytes and the store all keep their values.
- R7: While `match_mode` is high, every host read returns 32'hFFFFFFFF.
- R8: When `eng_rd` and `match_mode` are both high, `eng_rdata` loads the word at `eng_addr` on the next edge. Otherwise `eng_rdata` holds its value.
- R9: Bit 7 of the low register always reads as zero, whatever is written to it. Bits 31:16 of the high register always read as zero and are ignored on writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| match_mode | input | 1 | 1: the matching engine owns the store and the host is locked out |
| host_addr | input | HOST_AW (4) | Register byte offset |
| host_wr | input | 1 | Host write enable |
| host_rd | input | 1 | Host read enable |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| eng_rd | input | 1 | Engine read enable |
| eng_addr | input | 7 | Engine word index |
| eng_rdata | output | 40 | Registered engine read data |

## Verification
The assertions check the following on every cycle:
- A low write lands in the index one edge later.
- Host writes in match mode leave the index and the staged bytes untouched.
- Every commit is followed by a fetch.
- Reads in match mode return all ones.
- The reserved bit reads zero.
- The engine output holds unless an engine read is enabled.

Only the bench's scenarios can show the following:
- Whole words round-trip through the split registers for edge indices and data patterns.
- A low write alone leaves the store unchanged.
- A write dropped in match mode is still absent once the host regains the store.
- The staged bytes from an earlier low write end up in the committed word.

// File: rtl/patram_pkg.sv
package patram_pkg;
  localparam int unsigned HOST_DW    = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = 5;
  localparam int unsigned WORD_W     = WORD_BYTES * BYTE_W;
  localparam int unsigned PAT_DEPTH  = 128;
  localparam int unsigned PAT_AW     = $clog2(PAT_DEPTH);
  localparam int unsigned STAGE_W    = 3 * BYTE_W;

  typedef logic [WORD_W-1:0]  pat_word_t;
  typedef logic [PAT_AW-1:0]  pat_addr_t;
  typedef logic [HOST_DW-1:0] host_word_t;

  // full word from a high-register write plus the staged low bytes
  function automatic pat_word_t commit_word(host_word_t wd, logic [STAGE_W-1:0] staged);
    return {wd[2*BYTE_W-1:0], staged};
  endfunction

  // host view at offset 0x0: bytes 2..0, reserved zero bit, index
  function automatic host_word_t low_view(pat_word_t w, pat_addr_t a);
    host_word_t v;
    v = '0;
    v[PAT_AW-1:0] = a;
    v[HOST_DW-1:BYTE_W] = w[STAGE_W-1:0];
    return v;
  endfunction

  // host view at offset 0x4: bytes 4..3 in the low half, upper half zero
  function automatic host_word_t high_view(pat_word_t w);
    host_word_t v;
    v = '0;
    v[2*BYTE_W-1:0] = w[WORD_W-1:STAGE_W];
    return v;
  endfunction
endpackage

// File: rtl/patram_hostregs.sv
module patram_hostregs
  import patram_pkg::*;
#(
  parameter int unsigned HOST_AW  = 4,
  parameter int unsigned OFS_LOW  = 0,
  parameter int unsigned OFS_HIGH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               match_mode,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_wr,
  input  host_word_t         host_wdata,
  output pat_addr_t          addr_q,
  output logic [STAGE_W-1:0] staged_q,
  output logic               ram_we,
  output pat_word_t          ram_wdata,
  output logic               fetch_en
);
  logic hit_low, hit_high;
  logic unused_bits;

  assign hit_low  = host_wr && !match_mode && (host_addr == HOST_AW'(OFS_LOW));
  assign hit_high = host_wr && !match_mode && (host_addr == HOST_AW'(OFS_HIGH));

  assign ram_we    = hit_high;
  assign ram_wdata = commit_word(host_wdata, staged_q);
  assign unused_bits = ^{host_wdata[HOST_DW-1:2*BYTE_W], host_wdata[BYTE_W-1:PAT_AW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      staged_q <= '0;
      fetch_en <= 1'b0;
    end else begin
      fetch_en <= hit_low || hit_high;
      if (hit_low) begin
        addr_q   <= host_wdata[PAT_AW-1:0];
        staged_q <= host_wdata[HOST_DW-1:BYTE_W];
      end
    end
  end
endmodule

// File: rtl/patram_store.sv
module patram_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W     = 40,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          fetch_en,
  input  logic [AW-1:0] fetch_addr,
  output logic [W-1:0]  fetch_data,
  input  logic          eng_en,
  input  logic [AW-1:0] eng_addr,
  output logic [W-1:0]  eng_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_data <= '0;
      eng_data   <= '0;
    end else begin
      if (fetch_en) fetch_data <= mem[fetch_addr];
      if (eng_en)   eng_data   <= mem[eng_addr];
    end
  end
endmodule

// File: rtl/patram_rdmux.sv
module patram_rdmux
  import patram_pkg::*;
#(
  parameter int unsigned HOST_AW  = 4,
  parameter int unsigned OFS_LOW  = 0,
  parameter int unsigned OFS_HIGH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               match_mode,
  input  logic               host_rd,
  input  logic [HOST_AW-1:0] host_addr,
  input  pat_addr_t          addr_q,
  input  pat_word_t          rbuf,
  output host_word_t         host_rdata
);
  host_word_t sel;

  always_comb begin
    if (match_mode)                              sel = '1;
    else if (host_addr == HOST_AW'(OFS_LOW))     sel = low_view(rbuf, addr_q);
    else if (host_addr == HOST_AW'(OFS_HIGH))    sel = high_view(rbuf);
    else                                         sel = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= sel;
  end
endmodule

// File: rtl/patram_window.sv
module patram_window
  import patram_pkg::*;
#(
  parameter int unsigned HOST_AW  = 4,
  parameter int unsigned OFS_LOW  = 0,
  parameter int unsigned OFS_HIGH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               match_mode,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               eng_rd,
  input  logic [6:0]         eng_addr,
  output logic [39:0]        eng_rdata
);
  pat_addr_t          addr_q;
  logic [STAGE_W-1:0] staged_q;
  logic               ram_we;
  pat_word_t          ram_wdata;
  logic               fetch_en;
  pat_word_t          rbuf;
  logic               eng_en;

  assign eng_en = eng_rd && match_mode;

  patram_hostregs #(.HOST_AW(HOST_AW), .OFS_LOW(OFS_LOW), .OFS_HIGH(OFS_HIGH)) regs_i (
    .clk(clk), .rst_n(rst_n), .match_mode(match_mode), .host_addr(host_addr),
    .host_wr(host_wr), .host_wdata(host_wdata), .addr_q(addr_q), .staged_q(staged_q),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .fetch_en(fetch_en)
  );

  patram_store #(.DEPTH(PAT_DEPTH), .W(WORD_W)) store_i (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(addr_q), .wdata(ram_wdata),
    .fetch_en(fetch_en), .fetch_addr(addr_q), .fetch_data(rbuf),
    .eng_en(eng_en), .eng_addr(eng_addr), .eng_data(eng_rdata)
  );

  patram_rdmux #(.HOST_AW(HOST_AW), .OFS_LOW(OFS_LOW), .OFS_HIGH(OFS_HIGH)) rdmux_i (
    .clk(clk), .rst_n(rst_n), .match_mode(match_mode), .host_rd(host_rd),
    .host_addr(host_addr), .addr_q(addr_q), .rbuf(rbuf), .host_rdata(host_rdata)
  );
endmodule

// File: rtl/patram_window_chk.sv
module patram_window_chk #(
  parameter int unsigned HOST_AW  = 4,
  parameter int unsigned OFS_LOW  = 0,
  parameter int unsigned OFS_HIGH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               match_mode,
  input logic [HOST_AW-1:0] host_addr,
  input logic               host_wr,
  input logic               host_rd,
  input logic [31:0]        host_wdata,
  input logic [31:0]        host_rdata,
  input logic               eng_rd,
  input logic [39:0]        eng_rdata,
  input logic [6:0]         addr_q,
  input logic [23:0]        staged_q,
  input logic               ram_we,
  input logic               fetch_en
);
  assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !match_mode && host_addr == HOST_AW'(OFS_LOW)) |=> addr_q == $past(host_wdata[6:0]));

  assert_commit_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> fetch_en);

  assert_lockout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && match_mode) |=> ($stable(addr_q) && $stable(staged_q)));

  assert_lock_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && match_mode) |=> host_rdata == 32'hFFFF_FFFF);

  assert_eng_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_rd && match_mode) |=> $stable(eng_rdata));

  assert_rsv_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !match_mode && host_addr == HOST_AW'(OFS_LOW)) |=> !host_rdata[7]);
endmodule

bind patram_window patram_window_chk #(.HOST_AW(HOST_AW), .OFS_LOW(OFS_LOW), .OFS_HIGH(OFS_HIGH)) chk_i (
  .clk(clk), .rst_n(rst_n), .match_mode(match_mode), .host_addr(host_addr),
  .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .eng_rd(eng_rd), .eng_rdata(eng_rdata), .addr_q(addr_q), .staged_q(staged_q),
  .ram_we(ram_we), .fetch_en(fetch_en)
);

// File: tb/patram_window_tb_top.sv
`timescale 1ns/1ps
module patram_window_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        match_mode = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        eng_rd = 1'b0;
  logic [6:0]  eng_addr = '0;
  logic [39:0] eng_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  patram_window dut_i (
    .clk(clk), .rst_n(rst_n), .match_mode(match_mode), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_rd(eng_rd), .eng_addr(eng_addr), .eng_rdata(eng_rdata)
  );

  // {index, 40-bit word}; byte k is word bits 8k+7:8k
  localparam logic [46:0] VEC [6] = '{
    {7'd0,   40'h01_02_03_04_05},
    {7'd127, 40'hFF_FF_FF_FF_FF},
    {7'd5,   40'hA5_5A_C3_3C_0F},
    {7'd64,  40'h00_00_00_00_00},
    {7'd1,   40'h80_00_00_00_01},
    {7'd126, 40'h12_34_56_78_9A}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic hread(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic eread(input logic [6:0] a, output logic [39:0] d);
    @(negedge clk); eng_addr = a; eng_rd = 1'b1;
    @(negedge clk); eng_rd = 1'b0; d = eng_rdata;
  endtask

  function automatic logic [31:0] lowv(logic [39:0] w, logic [6:0] a);
    return {w[23:0], 1'b0, a};
  endfunction
  function automatic logic [31:0] highv(logic [39:0] w);
    return {16'h0000, w[39:24]};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2;
    logic [39:0] e;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 host_rdata", host_rdata, 0);
    chk("R1 eng_rdata", eng_rdata, 0);
    rst_n = 1'b1;
    hread(4'h0, r); chk("R1 low view after reset", r, 0);
    hread(4'h4, r); chk("R1 high view after reset", r, 0);
    hread(4'h8, r); chk("R5 unmapped offset", r, 0);

    // table: write word, read it back in alternating order
    foreach (VEC[i]) begin
      logic [6:0] a; logic [39:0] w;
      a = VEC[i][46:40]; w = VEC[i][39:0];
      hwrite(4'h0, {w[23:0], 1'b0, a});
      hwrite(4'h4, {16'h0000, w[39:24]});
      if (i % 2 == 0) begin
        hread(4'h0, r); hread(4'h4, r2);
      end else begin
        hread(4'h4, r2); hread(4'h0, r);
      end
      chk("R3 R4 low view", r, lowv(w, a));
      chk("R3 R4 high view", r2, highv(w));
    end

    // low write alone must not alter the store
    foreach (VEC[i]) begin
      logic [6:0] a; logic [39:0] w;
      a = VEC[i][46:40]; w = VEC[i][39:0];
      hwrite(4'h0, {24'hDEADBE, 1'b0, a});
      hread(4'h0, r); chk("R2 low write keeps store", r, lowv(w, a));
      hread(4'h4, r); chk("R2 high view intact", r, highv(w));
    end

    // R5 hold without read
    r2 = host_rdata;
    repeat (3) @(negedge clk);
    chk("R5 rdata holds", host_rdata, r2);

    // R9 reserved bit and upper half
    hwrite(4'h0, {24'hDEADBE, 1'b1, 7'd5});
    hread(4'h0, r); chk("R9 reserved bit reads zero", r, 32'hC33C0F05);
    hwrite(4'h4, 32'hFFFF_7788);
    hread(4'h4, r); chk("R9 R3 high upper half zero", r, 32'h0000_7788);

    // lockout
    @(negedge clk); match_mode = 1'b1;
    hwrite(4'h0, {24'h111111, 1'b0, 7'd127});
    hwrite(4'h4, 32'h0000_2222);
    hread(4'h0, r); chk("R7 locked low read", r, 32'hFFFF_FFFF);
    hread(4'h4, r); chk("R7 locked high read", r, 32'hFFFF_FFFF);
    eread(7'd5, e);   chk("R8 engine read idx5", e, 40'h7788DEADBE);
    eread(7'd127, e); chk("R8 engine read idx127", e, 40'hFFFFFFFFFF);
    @(negedge clk); match_mode = 1'b0;
    eread(7'd0, e);   chk("R8 engine held with mode low", e, 40'hFFFFFFFFFF);
    hread(4'h0, r); chk("R6 index and buffer unchanged", r, 32'hDEADBE05);
    hwrite(4'h0, {24'h000000, 1'b0, 7'd127});
    hread(4'h0, r); chk("R6 store low bytes unchanged", r, 32'hFFFFFF7F);
    hread(4'h4, r); chk("R6 store high bytes unchanged", r, 32'h0000FFFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule